// File: doc/BRIEF.md
# Interlocked Motor Run Controller

This block decides, one clock at a time, whether a single motor or pump is commanded to run. An operator start request can engage a sealed-in run state. The request counts only when the stop circuit and the monitored safety chain are healthy and every start permissive holds: the level is above its low-low limit, there is no overload, and no trip is latched. Once running, the motor keeps running until the operator presses stop, the safety chain opens, or a running interlock fires. The running interlocks are high discharge pressure, overtemperature, and a missing proof-of-run feedback.

Each trip cause latches in its own flag, and a summary flag is the OR of them. A reset input clears latched causes whose condition has gone away. A reset never starts the motor. Restoring the safety chain never restarts it either. After any trip, the operator must give a reset and then a fresh start press. Stop and safety inputs are active-high healthy, so a broken wire reads as a stop.

Top module: `motor_run_ctl`

## Requirements
- R1: After reset, run_cmd and every trip flag are 0. A start press that is held from before reset release cannot start the motor.
- R2: run_cmd goes to 1 on the clock edge after a 0-to-1 transition of start_pb, but only if all of these hold in that same cycle: stop_ok=1, safe_ok=1, lvl_ok=1, ovl_trip=0, trip_any=0 and reset_pb=0. Otherwise the press has no effect.
- R3: start_pb is edge-detected. If start_pb is held at 1 while a blocking condition clears, the motor does not start until start_pb is released and pressed again.
- R4: While running, run_cmd stays at 1 after start_pb is released. It drops to 0 on the next edge when stop_ok=0 or safe_ok=0.
- R5: Any cycle with safe_ok=0 sets trip_safe on the next edge. When safe_ok returns to 1, run_cmd stays at 0.
- R6: proof_fb must be seen within PROOF_TICKS cycles of run_cmd going to 1. If it is not, run_cmd stays at 1 for exactly PROOF_TICKS cycles, then trip_proof sets and run_cmd drops on the same edge. If proof_fb arrives in time, the motor keeps running.
- R7: hi_press=1 while running sets trip_press, and run_cmd drops on the next edge.
- R8: over_temp=1 while running sets trip_temp, and run_cmd drops on the next edge.
- R9: Each trip flag stays set until reset_pb=1 is seen in a cycle where that flag's own condition is absent. The conditions are: hi_press for trip_press, over_temp for trip_temp, and safe_ok=0 for trip_safe. trip_proof has no persisting condition. While the condition is present, reset leaves the flag set.
- R10: reset_pb never sets run_cmd. A start press in the same cycle as reset_pb=1 is ignored.
- R11: trip_any is the OR of the four trip flags. While it is 1, no start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_pb | input | 1 | Start pushbutton, 1 = pressed |
| stop_ok | input | 1 | Stop circuit healthy, 0 = stop |
| safe_ok | input | 1 | Safety chain healthy, 0 = safety lost |
| lvl_ok | input | 1 | Level above low-low limit |
| ovl_trip | input | 1 | Motor overload tripped |
| hi_press | input | 1 | High discharge pressure switch |
| over_temp | input | 1 | Overtemperature switch |
| proof_fb | input | 1 | Proof-of-run feedback |
| reset_pb | input | 1 | Operator trip reset |
| run_cmd | output | 1 | Motor run command |
| trip_press | output | 1 | Latched high-pressure trip |
| trip_proof | output | 1 | Latched proof-fail trip |
| trip_temp | output | 1 | Latched overtemperature trip |
| trip_safe | output | 1 | Latched safety-loss trip |
| trip_any | output | 1 | OR of all trip flags |

## Verification
The hardest case to reach is a proof timeout that lands exactly on the PROOF_TICKS boundary. A feedback that arrives one cycle too late must trip, and one that arrives in time must not. The bench shortens PROOF_TICKS, holds proof_fb low from the start press, and counts the cycles in which run_cmd is high until it falls. A second run raises proof_fb partway through the window. The restart rules are also checked at the ports. One sequence holds the start button through a permissive change. Another drops and restores the safety chain, then tries start before reset, with reset, and after reset.

// File: rtl/motor_run_ctl.sv
module motor_run_ctl #(
  parameter int PROOF_TICKS = 30_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_pb,
  input  logic stop_ok,
  input  logic safe_ok,
  input  logic lvl_ok,
  input  logic ovl_trip,
  input  logic hi_press,
  input  logic over_temp,
  input  logic proof_fb,
  input  logic reset_pb,
  output logic run_cmd,
  output logic trip_press,
  output logic trip_proof,
  output logic trip_temp,
  output logic trip_safe,
  output logic trip_any
);
  localparam int CW = $clog2(PROOF_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(PROOF_TICKS - 1);

  logic          start_q;
  logic          proven;
  logic [CW-1:0] cnt;

  wire start_edge = start_pb & ~start_q;
  wire permit     = stop_ok & safe_ok & lvl_ok & ~ovl_trip & ~trip_any & ~reset_pb;
  wire timeout    = run_cmd & ~proven & ~proof_fb & (cnt == LAST);
  wire keep       = stop_ok & safe_ok & ~hi_press & ~over_temp & ~timeout;

  assign trip_any = trip_press | trip_proof | trip_temp | trip_safe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q    <= 1'b1;
      run_cmd    <= 1'b0;
      proven     <= 1'b0;
      cnt        <= '0;
      trip_press <= 1'b0;
      trip_proof <= 1'b0;
      trip_temp  <= 1'b0;
      trip_safe  <= 1'b0;
    end else begin
      start_q <= start_pb;
      run_cmd <= run_cmd ? keep : (start_edge & permit);

      if (!run_cmd) begin
        proven <= 1'b0;
        cnt    <= '0;
      end else if (!proven) begin
        proven <= proof_fb;
        cnt    <= cnt + 1'b1;
      end

      trip_press <= (run_cmd & hi_press)  | (trip_press & ~(reset_pb & ~hi_press));
      trip_temp  <= (run_cmd & over_temp) | (trip_temp  & ~(reset_pb & ~over_temp));
      trip_safe  <= ~safe_ok              | (trip_safe  & ~(reset_pb & safe_ok));
      trip_proof <= timeout               | (trip_proof & ~reset_pb);
    end
  end

  a_r2_start_needs_permit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_cmd) |-> $past(start_pb && stop_ok && safe_ok && lvl_ok && !ovl_trip && !trip_any));

  a_r4_seal_collapse: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cmd && (!stop_ok || !safe_ok || hi_press || over_temp)) |=> !run_cmd);

  a_r5_safety_latched: assert property (@(posedge clk) disable iff (!rst_n)
    !safe_ok |=> trip_safe && !run_cmd);

  a_r6_proof_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_proof) |-> $past(run_cmd) && !run_cmd);

  a_r9_trip_held: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_any && !reset_pb) |=> trip_any);

  a_r10_reset_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_cmd) |-> !$past(reset_pb));
endmodule

// File: tb/motor_run_ctl_tb.sv
module motor_run_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS = 8;

  logic clk = 0, rst_n = 0;
  logic start_pb = 0, stop_ok = 1, safe_ok = 1, lvl_ok = 1, ovl_trip = 0;
  logic hi_press = 0, over_temp = 0, proof_fb = 1, reset_pb = 0;
  logic run_cmd, trip_press, trip_proof, trip_temp, trip_safe, trip_any;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  motor_run_ctl #(.PROOF_TICKS(TICKS)) dut_i (
    .clk, .rst_n, .start_pb, .stop_ok, .safe_ok, .lvl_ok, .ovl_trip,
    .hi_press, .over_temp, .proof_fb, .reset_pb,
    .run_cmd, .trip_press, .trip_proof, .trip_temp, .trip_safe, .trip_any);

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_pb = 1; tick(); start_pb = 0; tick();
  endtask

  task automatic pulse_reset();
    reset_pb = 1; tick(); reset_pb = 0; tick();
  endtask

  task automatic t_reset();
    start_pb = 1;
    tick(3); rst_n = 1; tick(3);
    check("R1 run after reset", run_cmd, 0);
    check("R1 trips after reset", trip_any, 0);
    start_pb = 0; tick();
  endtask

  task automatic t_basic();
    pulse_start();
    check("R2 start", run_cmd, 1);
    tick(5);
    check("R4 seal holds", run_cmd, 1);
    stop_ok = 0; tick(); stop_ok = 1;
    check("R4 stop drops", run_cmd, 0);
    check("R4 stop no trip", trip_any, 0);
    tick();
  endtask

  task automatic t_permissives();
    ovl_trip = 1; pulse_start();
    check("R2 overload blocks", run_cmd, 0);
    ovl_trip = 0;
    lvl_ok = 0; start_pb = 1; tick();
    check("R2 low level blocks", run_cmd, 0);
    lvl_ok = 1; tick(3);
    check("R3 held start ignored", run_cmd, 0);
    start_pb = 0; tick();
    pulse_start();
    check("R3 fresh press starts", run_cmd, 1);
    stop_ok = 0; tick(); stop_ok = 1; tick();
  endtask

  task automatic t_safety();
    pulse_start();
    safe_ok = 0; tick();
    check("R4 safety drops run", run_cmd, 0);
    check("R5 safety latch", trip_safe, 1);
    check("R11 summary", trip_any, 1);
    pulse_reset();
    check("R9 reset while unsafe keeps trip", trip_safe, 1);
    safe_ok = 1; tick(4);
    check("R5 no restart on restore", run_cmd, 0);
    pulse_start();
    check("R11 trip blocks start", run_cmd, 0);
    reset_pb = 1; start_pb = 1; tick(); start_pb = 0; reset_pb = 0; tick();
    check("R10 start with reset ignored", run_cmd, 0);
    check("R9 reset clears safe", trip_safe, 0);
    pulse_start();
    check("R9 reset plus start runs", run_cmd, 1);
    stop_ok = 0; tick(); stop_ok = 1; tick();
  endtask

  task automatic t_proof();
    int hi_cycles = 0;
    proof_fb = 0;
    start_pb = 1; tick(); start_pb = 0;
    for (int i = 0; i < 20 && run_cmd; i++) begin hi_cycles++; tick(); end
    n_chk++;
    if (hi_cycles != TICKS) begin
      n_fail++;
      $display("FAIL R6 run cycles: actual %0d expected %0d", hi_cycles, TICKS);
    end
    check("R6 proof trip", trip_proof, 1);
    pulse_reset();
    check("R9 proof cleared", trip_proof, 0);
    start_pb = 1; tick(); start_pb = 0;
    tick(TICKS - 2); proof_fb = 1; tick(10);
    check("R6 late-in-window proof runs", run_cmd, 1);
    check("R6 no proof trip", trip_proof, 0);
    stop_ok = 0; tick(); stop_ok = 1; tick();
  endtask

  task automatic t_press_temp();
    pulse_start();
    hi_press = 1; tick();
    check("R7 pressure drops run", run_cmd, 0);
    check("R7 pressure trip", trip_press, 1);
    pulse_reset();
    check("R9 reset with pressure held", trip_press, 1);
    hi_press = 0; pulse_reset();
    check("R9 pressure cleared", trip_press, 0);
    check("R10 reset no run", run_cmd, 0);
    pulse_start();
    over_temp = 1; tick(); over_temp = 0;
    check("R8 temp drops run", run_cmd, 0);
    check("R8 temp trip", trip_temp, 1);
    check("R11 summary temp", trip_any, 1);
    pulse_reset();
    check("R9 temp cleared", trip_temp, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_permissives();
    t_safety();
    t_proof();
    t_press_temp();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule